// File: doc/BRIEF.md
# Stereo Audio Serial Transmitter

This block takes 32-bit stereo sample words and sends them bit by bit to an external 16-bit audio DAC. Each word carries the left channel in its upper half and the right channel in its lower half. The block runs entirely from the master audio clock. It divides that clock down to a shift clock, and it drives a serial data line and a channel word-select line. The DAC captures data on the rising edges of the shift clock.

The block asks for the next word with a valid/ready handshake, which opens only during the last bit of each frame. A DMA engine or another producer answers it. If no word arrives before the frame boundary, the block sends the previous sample again and raises an underrun indication for the whole of that frame. The master clock is expected at 256 times the sample rate, for example 11.2896 MHz at 44.1 kHz. With the default divider, this gives exactly 32 shift clocks per sample period.

Top module: `stereo_serial_tx`

## Requirements
- R1: `sclk` has a period of `CLK_DIV` master clock cycles, default 8, and is high for exactly half of that period.
- R2: A frame is 32 `sclk` periods long. It sends word bits 31 down to 16 as the left channel, then bits 15 down to 0 as the right channel, so each channel goes most significant bit first.
- R3: `sdata` changes only on a falling edge of `sclk`. It is therefore stable at every rising edge.
- R4: `wsel` is 1 for the 16 left-channel bits and 0 for the 16 right-channel bits. It changes on the same falling edge that launches each channel's first bit.
- R5: `sampleReady` is 1 only during the last bit period of a frame, and only while no word has yet been accepted in that period. It goes to 0 on the cycle after a handshake in which `sampleValid` and `sampleReady` are both 1.
- R6: A word accepted during the last bit of a frame is the word sent in the next frame.
- R7: If no word is accepted during the last bit, the next frame repeats the previously accepted word and `underrun` is 1 for that frame. `underrun` returns to 0 at the start of the next frame that carries a fresh word.
- R8: In reset, `sclk`, `sdata`, `wsel` and `underrun` are 0 and `sampleReady` is 1. The stored sample resets to zero, so a first frame with no accepted word sends all zeros with `underrun` set to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master audio clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleData | input | 32 | Stereo word: left in bits 31:16, right in bits 15:0 |
| sampleValid | input | 1 | Producer offers `sampleData` |
| sampleReady | output | 1 | Block accepts a word this cycle |
| sclk | output | 1 | Shift clock to the DAC |
| sdata | output | 1 | Serial data, launched on falling `sclk` |
| wsel | output | 1 | Channel select: 1 for left, 0 for right |
| underrun | output | 1 | Current frame repeats the previous sample |

## Verification
The bench runs a sequence of frames. The sequence includes a missing word right after reset, two consecutive missing words, and the extreme patterns all-ones, all-zeros and a word with only its outermost bits set. It rebuilds every frame from the serial line at the rising shift-clock edges.

A design that shifted least significant bit first, or swapped the channel halves, would show up as a wrong rebuilt word. A design that moved word select by one bit would show up as a wrong select value on the first or last bit of a channel. A design that let data change on the rising edge would show data moving away from a falling edge.

If a design cleared its stored word on underrun, or flagged underrun only for one cycle, the repeated frames and the per-frame flag would not match. If it kept `sampleReady` high after the handshake, or raised it outside the last bit, the check on the cycle after acceptance and the per-bit ready checks would catch it.

// File: rtl/stereo_tx_pkg.sv
package stereo_tx_pkg;

  // Strobes from the control section into the datapath
  typedef struct packed {
    logic capture;    // handshake completes this cycle
    logic launch;     // falling shift-clock edge: advance one bit
    logic frameLoad;  // falling edge that starts a new frame
    logic bypass;     // capture and frameLoad coincide: load straight from input
  } txStrobes_t;

endpackage

// File: rtl/stereo_tx_ctrl.sv
module stereo_tx_ctrl
  import stereo_tx_pkg::*;
#(
  parameter int CLK_DIV   = 8,
  parameter int CHAN_BITS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleValid,
  output logic       sampleReady,
  output logic       sclk,
  output logic       wsel,
  output logic       underrun,
  output txStrobes_t strobes
);
  localparam int HALF       = CLK_DIV / 2;
  localparam int DIV_W      = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int FRAME_BITS = 2 * CHAN_BITS;
  localparam int BIT_W      = $clog2(FRAME_BITS);

  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitIdx;
  logic [BIT_W-1:0] nextBitIdx;
  logic             taken;
  logic             sclkQ;
  logic             wselQ;
  logic             underrunQ;
  logic             launchTick;
  logic             riseTick;
  logic             lastBit;
  logic             captureNow;

  assign launchTick = (divCnt == DIV_W'(CLK_DIV - 1));
  assign riseTick   = (divCnt == DIV_W'(HALF - 1));
  assign lastBit    = (bitIdx == BIT_W'(FRAME_BITS - 1));
  assign nextBitIdx = lastBit ? '0 : bitIdx + 1'b1;

  assign sampleReady = lastBit && !taken;
  assign captureNow  = sampleValid && sampleReady;

  always_comb begin
    strobes.capture   = captureNow;
    strobes.launch    = launchTick;
    strobes.frameLoad = launchTick && lastBit;
    strobes.bypass    = launchTick && lastBit && captureNow;
  end

  // Master clock divider
  always_ff @(posedge clk) begin
    if (!rstN)           divCnt <= '0;
    else if (launchTick) divCnt <= '0;
    else                 divCnt <= divCnt + 1'b1;
  end

  // Shift clock: rises half-way through the bit, falls at the bit boundary
  always_ff @(posedge clk) begin
    if (!rstN)           sclkQ <= 1'b0;
    else if (launchTick) sclkQ <= 1'b0;
    else if (riseTick)   sclkQ <= 1'b1;
  end

  // Bit position and channel select
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitIdx <= BIT_W'(FRAME_BITS - 1);
      wselQ  <= 1'b0;
    end else if (launchTick) begin
      bitIdx <= nextBitIdx;
      wselQ  <= (nextBitIdx < BIT_W'(CHAN_BITS));
    end
  end

  // Handshake bookkeeping and underrun per frame
  always_ff @(posedge clk) begin
    if (!rstN) begin
      taken     <= 1'b0;
      underrunQ <= 1'b0;
    end else if (launchTick && lastBit) begin
      taken     <= 1'b0;
      underrunQ <= !(taken || captureNow);
    end else if (captureNow) begin
      taken     <= 1'b1;
    end
  end

  assign sclk     = sclkQ;
  assign wsel     = wselQ;
  assign underrun = underrunQ;

endmodule

// File: rtl/stereo_tx_datapath.sv
module stereo_tx_datapath
  import stereo_tx_pkg::*;
#(
  parameter int CHAN_BITS = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [2*CHAN_BITS-1:0] sampleData,
  input  txStrobes_t             strobes,
  output logic                   sdata
);
  localparam int FRAME_BITS = 2 * CHAN_BITS;

  logic [FRAME_BITS-1:0] heldWord;
  logic [FRAME_BITS-1:0] shiftReg;

  // Last accepted word; kept on underrun so the frame repeats
  always_ff @(posedge clk) begin
    if (!rstN)                heldWord <= '0;
    else if (strobes.capture) heldWord <= sampleData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  shiftReg <= '0;
    else if (strobes.frameLoad) shiftReg <= strobes.bypass ? sampleData : heldWord;
    else if (strobes.launch)    shiftReg <= {shiftReg[FRAME_BITS-2:0], 1'b0};
  end

  assign sdata = shiftReg[FRAME_BITS-1];

endmodule

// File: rtl/stereo_serial_tx.sv
module stereo_serial_tx
  import stereo_tx_pkg::*;
#(
  parameter int CLK_DIV   = 8,
  parameter int CHAN_BITS = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [2*CHAN_BITS-1:0] sampleData,
  input  logic                   sampleValid,
  output logic                   sampleReady,
  output logic                   sclk,
  output logic                   sdata,
  output logic                   wsel,
  output logic                   underrun
);
  txStrobes_t strobes;

  stereo_tx_ctrl #(.CLK_DIV(CLK_DIV), .CHAN_BITS(CHAN_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleReady(sampleReady),
    .sclk(sclk), .wsel(wsel), .underrun(underrun), .strobes(strobes)
  );

  stereo_tx_datapath #(.CHAN_BITS(CHAN_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .sampleData(sampleData), .strobes(strobes), .sdata(sdata)
  );

endmodule

// File: rtl/stereo_serial_tx_checks.sv
module stereo_serial_tx_checks (
  input logic clk,
  input logic rstN,
  input logic sampleValid,
  input logic sampleReady,
  input logic sclk,
  input logic sdata,
  input logic wsel,
  input logic underrun
);
  assert_data_on_fall_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdata) |-> $fell(sclk));

  assert_wsel_on_fall_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(wsel) |-> $fell(sclk));

  assert_ready_opens_at_last_bit_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sampleReady) |-> ($fell(sclk) && !wsel));

  assert_ready_drops_after_accept_R5: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && sampleReady) |=> !sampleReady);

  assert_underrun_at_frame_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(underrun) |-> ($fell(sclk) && $rose(wsel)));
endmodule

bind stereo_serial_tx stereo_serial_tx_checks u_checks (
  .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleReady(sampleReady),
  .sclk(sclk), .sdata(sdata), .wsel(wsel), .underrun(underrun)
);

// File: tb/stereo_serial_tx_test.sv
module stereo_serial_tx_test;
  localparam int NF = 24;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] sampleData = '0;
  logic        sampleValid = 1'b0;
  logic        sampleReady, sclk, sdata, wsel, underrun;

  int  checks = 0;
  int  fails = 0;
  bit  finished = 0;
  int  framesDone = 0;

  logic [31:0] expWord [NF];
  bit          expUnder [NF];

  always #10 clk = ~clk;

  stereo_serial_tx uut (
    .clk(clk), .rstN(rstN), .sampleData(sampleData), .sampleValid(sampleValid),
    .sampleReady(sampleReady), .sclk(sclk), .sdata(sdata), .wsel(wsel), .underrun(underrun)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  function automatic logic [31:0] wordFor(int k);
    case (k)
      2:       return 32'hFFFF_FFFF;
      4:       return 32'h8000_0001;
      6:       return 32'h0000_0000;
      7:       return 32'hFFFF_0000;
      default: return (k * 32'h9E37_79B9) ^ 32'h5A5A_C3C3;
    endcase
  endfunction

  function automatic bit gives(int k);
    return !(k == 0 || (k % 5) == 3 || k == 9);
  endfunction

  // Producer and expected-value model
  initial begin
    logic [31:0] cur;
    cur = '0;
    repeat (5) @(negedge clk);
    // R8: reset state
    check(sclk == 0 && sdata == 0 && wsel == 0 && underrun == 0, "R8 outputs", {sclk, sdata, wsel, underrun}, 0);
    check(sampleReady == 1, "R8 ready", sampleReady, 1);
    rstN = 1'b1;
    for (int k = 0; k < NF; k++) begin
      while (!sampleReady) @(negedge clk);
      if (gives(k)) begin
        sampleData  = wordFor(k);
        sampleValid = 1'b1;
        @(negedge clk);
        check(sampleReady == 0, "R5 ready after accept", sampleReady, 0);
        sampleValid = 1'b0;
        sampleData  = 32'hDEAD_BEEF;
        cur = wordFor(k);
        expUnder[k] = 0;
      end else begin
        expUnder[k] = 1;
      end
      expWord[k] = cur;
      while (sampleReady) @(negedge clk);
    end
    while (framesDone < NF) @(negedge clk);
    finishRun();
  end

  // Monitor: rebuild frames from the serial line
  time         lastRise = 0;
  time         lastFall = 0;
  bit          prevWsel = 0;
  bit          inFrame = 0;
  int          pos = 0;
  int          curFrame = 0;
  int          nextFrame = 0;
  logic [31:0] bits = '0;

  always @(posedge sclk) begin
    if (rstN) begin
      if (lastRise != 0) check(($time - lastRise) == 160, "R1 period", 32'($time - lastRise), 160);
      lastRise = $time;
      if (wsel && !prevWsel) begin
        inFrame = 1;
        pos = 0;
        curFrame = nextFrame;
        nextFrame++;
        if (curFrame < NF)
          check(underrun == expUnder[curFrame], "R7 underrun flag", underrun, expUnder[curFrame]);
      end
      prevWsel = wsel;
      if (inFrame && curFrame < NF) begin
        bits[31-pos] = sdata;
        check(wsel == (pos < 16), "R4 word select", wsel, (pos < 16));
        if (pos < 31) check(sampleReady == 0, "R5 ready outside last bit", sampleReady, 0);
        pos++;
        if (pos == 32) begin
          check(bits == expWord[curFrame], "R2 R6 frame word", bits, expWord[curFrame]);
          inFrame = 0;
          framesDone++;
        end
      end
    end
  end

  always @(negedge sclk) begin
    lastFall = $time;
    if (rstN && lastRise != 0)
      check(($time - lastRise) == 80, "R1 high time", 32'($time - lastRise), 80);
  end

  always @(sdata) begin
    #1;
    if (rstN) check(sclk == 0 && ($time - lastFall) == 1, "R3 data moves on falling edge", 32'($time - lastFall), 1);
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end
endmodule